// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host side of a two-wire serial debug link. It carries out one register access per request: a read or a write to either a debug-port or an access-port register, picked by a 2-bit register address. It frames the 8-bit request header, hands the data line to the target and takes it back, collects the 3-bit acknowledge, and then moves 32 data bits plus a parity bit in the direction the request names.

The engine generates the serial clock from the system clock. Each serial bit lasts `2*HALF_DIV` system clocks. The first half is clock-low and the second half is clock-high. The host changes its data only where a bit begins, which is right after a falling edge. It samples the incoming line in the last system clock before the rising edge. An acknowledge other than OK cuts the transfer short. The one exception is a write issued with the ignore-acknowledge input set, which always sends its data. Higher-level sequencing such as line resets, wake-up sequences and retry on WAIT is left to the logic that issues requests.

Top module: `swd_xact_engine`

## Requirements
- R1: The request header leaves in the order start=1, access-port flag (1 = access port), read flag (1 = read), address bit 0, address bit 1, parity, stop=0, park=1. The host drives the line during all eight bits.
- R2: The header parity bit is the XOR of the access-port flag, the read flag and both address bits, so the count of ones over those five bits is even.
- R3: Every serial bit lasts 2*HALF_DIV system clocks. `swclk_o` is low for the first HALF_DIV and high for the second. It idles low.
- R4: After the park bit, the output enable is low for one turnaround bit and then for three acknowledge bits. The acknowledge is taken least significant bit first, from the value on `swdio_i` in the system clock before each rising edge. Only 3'b001 counts as OK.
- R5: On a write with acknowledge OK, the host drives one turnaround bit of 0, then the 32 write-data bits least significant first, then one bit that makes the ones count of data plus parity even.
- R6: On a read with acknowledge OK, the line stays released for 32 data bits (least significant first) and one parity bit. The host then drives one turnaround bit of 0.
- R7: An acknowledge other than OK (on a read, or on a write without ignore-acknowledge) is followed by exactly one driven turnaround bit of 0 and then the end of the transaction. `rdata_o` keeps its previous value.
- R8: With `ign_ack_i` set, a write sends its full data phase whatever acknowledge arrives. On a read, `ign_ack_i` has no effect.
- R9: `par_err_o` is 1 after a completed read whose 33 received bits hold an odd number of ones, and 0 after any other transaction. The read data is returned in either case.
- R10: `done_o` pulses for one clock when the transaction ends. `ack_o`, `rdata_o` and `par_err_o` change only on that clock. Out of reset and between transactions, the outputs are clock low, enable high and data 0, and all result outputs are 0.
- R11: A `req_i` raised while a transaction is in progress is ignored and does not alter the ongoing line activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start strobe, accepted when idle |
| ap_sel_i | input | 1 | 1 selects an access-port register, 0 a debug-port register |
| rnw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 2 | Register address bits [3:2] |
| wdata_i | input | 32 | Write data |
| ign_ack_i | input | 1 | Write continues whatever acknowledge arrives |
| rdata_o | output | 32 | Last read data |
| ack_o | output | 3 | Last acknowledge received |
| par_err_o | output | 1 | Read data parity error |
| done_o | output | 1 | One-clock end-of-transaction pulse |
| swclk_o | output | 1 | Serial clock to the target |
| swdio_o | output | 1 | Serial data driven by the host |
| swdio_oe_o | output | 1 | Drive enable for swdio_o |
| swdio_i | input | 1 | Serial data as seen at the pad |

## Verification
The per-bit sequencing is compared against an independent bit list in every system clock. A phase counter that is off by one therefore shows within one serial bit as a wrong enable or a wrong data level. The same error also moves the clock edges relative to the bit boundaries, which is visible at once. A wrong acknowledge decision shows first as the enable: it rises too early or stays low too long just after the third acknowledge bit. The wrong `done_o` timing follows. Faults in the receive path that the line does not reveal surface at the single `done_o` clock through `rdata_o`, `ack_o` or `par_err_o`.

// File: rtl/swd_xact_pkg.sv
package swd_xact_pkg;
  localparam int REQ_W = 8;
  localparam int ACK_W = 3;
  localparam logic [ACK_W-1:0] ACK_OK = 3'b001;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_REQ,
    PH_TRN_RX,
    PH_ACK,
    PH_TRN_WR,
    PH_WDATA,
    PH_WPAR,
    PH_RDATA,
    PH_RPAR,
    PH_TRN_END
  } phase_e;
endpackage

// File: rtl/swd_req_encode.sv
module swd_req_encode
  import swd_xact_pkg::*;
(
  input  logic             ap_i,
  input  logic             rnw_i,
  input  logic [1:0]       addr_i,
  output logic [REQ_W-1:0] req_o
);
  logic par;
  always_comb begin
    par   = ap_i ^ rnw_i ^ addr_i[0] ^ addr_i[1];
    // index 0 goes out first: start, ap, rnw, a2, a3, parity, stop, park
    req_o = {1'b1, 1'b0, par, addr_i[1], addr_i[0], rnw_i, ap_i, 1'b1};
  end
endmodule

// File: rtl/swd_bit_timer.sv
module swd_bit_timer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic swclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          hi_q;
  logic          wrap;

  assign wrap    = run_i && (cnt_q == LAST);
  assign rise_o  = wrap && !hi_q;
  assign fall_o  = wrap && hi_q;
  assign swclk_o = hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else if (run_i) begin
      if (wrap) begin
        cnt_q <= '0;
        hi_q  <= !hi_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/swd_xact_ctrl.sv
module swd_xact_ctrl
  import swd_xact_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              rnw_i,
  input  logic              ign_ack_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [REQ_W-1:0]  req_word_i,
  input  logic              swdio_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic              start_o,
  output logic              busy_o,
  output logic              swdio_o,
  output logic              swdio_oe_o,
  output logic              done_o,
  output logic [ACK_W-1:0]  ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              par_err_o
);
  localparam int BW = $clog2(DATA_W);
  localparam logic [BW-1:0] LAST_DATA = BW'(DATA_W - 1);
  localparam logic [BW-1:0] LAST_REQ  = BW'(REQ_W - 1);
  localparam logic [BW-1:0] LAST_ACK  = BW'(ACK_W - 1);

  phase_e            ph_q;
  logic [BW-1:0]     bit_q;
  logic              rnw_q, ign_q, wpar_q, rd_ok_q, rpar_q;
  logic [REQ_W-1:0]  req_sr;
  logic [DATA_W-1:0] tx_sr, rx_sr;
  logic [ACK_W-1:0]  ack_sr;
  logic              ack_ok;

  assign start_o = req_i && (ph_q == PH_IDLE);
  assign busy_o  = (ph_q != PH_IDLE);
  assign ack_ok  = (ack_sr == ACK_OK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_IDLE;
      bit_q      <= '0;
      rnw_q      <= 1'b0;
      ign_q      <= 1'b0;
      wpar_q     <= 1'b0;
      rd_ok_q    <= 1'b0;
      rpar_q     <= 1'b0;
      req_sr     <= '0;
      tx_sr      <= '0;
      rx_sr      <= '0;
      ack_sr     <= '0;
      swdio_o    <= 1'b0;
      swdio_oe_o <= 1'b1;
      done_o     <= 1'b0;
      ack_o      <= '0;
      rdata_o    <= '0;
      par_err_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_o) begin
        ph_q       <= PH_REQ;
        bit_q      <= '0;
        rnw_q      <= rnw_i;
        ign_q      <= ign_ack_i;
        wpar_q     <= ^wdata_i;
        rd_ok_q    <= 1'b0;
        req_sr     <= req_word_i;
        tx_sr      <= wdata_i;
        swdio_o    <= req_word_i[0];
        swdio_oe_o <= 1'b1;
      end
      // sample in the clock just before the rising edge
      if (rise_i) begin
        unique case (ph_q)
          PH_ACK:   ack_sr <= {swdio_i, ack_sr[ACK_W-1:1]};
          PH_RDATA: rx_sr  <= {swdio_i, rx_sr[DATA_W-1:1]};
          PH_RPAR:  rpar_q <= swdio_i;
          default: ;
        endcase
      end
      // bit boundary: set up the next bit
      if (fall_i) begin
        bit_q <= bit_q + 1'b1;
        unique case (ph_q)
          PH_REQ: begin
            if (bit_q == LAST_REQ) begin
              ph_q       <= PH_TRN_RX;
              swdio_oe_o <= 1'b0;
            end else begin
              req_sr  <= req_sr >> 1;
              swdio_o <= req_sr[1];
            end
          end
          PH_TRN_RX: begin
            ph_q  <= PH_ACK;
            bit_q <= '0;
          end
          PH_ACK: begin
            if (bit_q == LAST_ACK) begin
              bit_q <= '0;
              if (rnw_q && ack_ok) begin
                ph_q    <= PH_RDATA;
                rd_ok_q <= 1'b1;
              end else begin
                ph_q       <= (!rnw_q && (ack_ok || ign_q)) ? PH_TRN_WR : PH_TRN_END;
                swdio_oe_o <= 1'b1;
                swdio_o    <= 1'b0;
              end
            end
          end
          PH_TRN_WR: begin
            ph_q    <= PH_WDATA;
            bit_q   <= '0;
            swdio_o <= tx_sr[0];
          end
          PH_WDATA: begin
            if (bit_q == LAST_DATA) begin
              ph_q    <= PH_WPAR;
              swdio_o <= wpar_q;
            end else begin
              tx_sr   <= tx_sr >> 1;
              swdio_o <= tx_sr[1];
            end
          end
          PH_RDATA: begin
            if (bit_q == LAST_DATA) ph_q <= PH_RPAR;
          end
          PH_RPAR: begin
            ph_q       <= PH_TRN_END;
            swdio_oe_o <= 1'b1;
            swdio_o    <= 1'b0;
          end
          PH_WPAR, PH_TRN_END: begin
            ph_q       <= PH_IDLE;
            swdio_oe_o <= 1'b1;
            swdio_o    <= 1'b0;
            done_o     <= 1'b1;
            ack_o      <= ack_sr;
            par_err_o  <= rd_ok_q && (^rx_sr ^ rpar_q);
            if (rd_ok_q) rdata_o <= rx_sr;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/swd_xact_engine.sv
module swd_xact_engine
  import swd_xact_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              ap_sel_i,
  input  logic              rnw_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ign_ack_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ACK_W-1:0]  ack_o,
  output logic              par_err_o,
  output logic              done_o,
  output logic              swclk_o,
  output logic              swdio_o,
  output logic              swdio_oe_o,
  input  logic              swdio_i
);
  logic [REQ_W-1:0] req_word;
  logic start, busy, rise, fall;

  swd_req_encode u_enc (
    .ap_i   (ap_sel_i),
    .rnw_i  (rnw_i),
    .addr_i (addr_i),
    .req_o  (req_word)
  );

  swd_bit_timer #(.HALF_DIV(HALF_DIV)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .run_i   (busy),
    .swclk_o (swclk_o),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  swd_xact_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .rnw_i      (rnw_i),
    .ign_ack_i  (ign_ack_i),
    .wdata_i    (wdata_i),
    .req_word_i (req_word),
    .swdio_i    (swdio_i),
    .rise_i     (rise),
    .fall_i     (fall),
    .start_o    (start),
    .busy_o     (busy),
    .swdio_o    (swdio_o),
    .swdio_oe_o (swdio_oe_o),
    .done_o     (done_o),
    .ack_o      (ack_o),
    .rdata_o    (rdata_o),
    .par_err_o  (par_err_o)
  );
endmodule

// File: rtl/swd_xact_sva.sv
module swd_xact_sva #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              swclk_o,
  input logic              swdio_o,
  input logic              swdio_oe_o,
  input logic              done_o,
  input logic [2:0]        ack_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              par_err_o
);
  // R10: end strobe lasts a single clock
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10: lines back at idle levels when the transaction ends
  a_r10_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!swclk_o && swdio_oe_o && !swdio_o));

  // R10: results move only with done
  a_r10_results_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(ack_o) && $stable(rdata_o) && $stable(par_err_o)));

  // R3: host never changes its drive while the clock is high
  a_r3_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swclk_o && $past(swclk_o)) |-> ($stable(swdio_o) && $stable(swdio_oe_o)));

  // R4: the line is released only at a bit start, clock low
  a_r4_release_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(swdio_oe_o) |-> !swclk_o);
endmodule

bind swd_xact_engine swd_xact_sva #(.DATA_W(DATA_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .swclk_o    (swclk_o),
  .swdio_o    (swdio_o),
  .swdio_oe_o (swdio_oe_o),
  .done_o     (done_o),
  .ack_o      (ack_o),
  .rdata_o    (rdata_o),
  .par_err_o  (par_err_o)
);

// File: tb/sim_swd_xact_engine.sv
`timescale 1ns/1ps
module sim_swd_xact_engine;
  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, ap = 1'b0, rnw = 1'b0, ign = 1'b0, din = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  ack;
  logic        perr, done, swclk, dout, oe;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] exp_rd = '0;

  bit    q_oe[$], q_do[$], q_ti[$];
  string q_tag[$];

  always #2 clk = !clk;

  swd_xact_engine #(.HALF_DIV(H), .DATA_W(32)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ap_sel_i(ap), .rnw_i(rnw),
    .addr_i(addr), .wdata_i(wdata), .ign_ack_i(ign), .rdata_o(rdata),
    .ack_o(ack), .par_err_o(perr), .done_o(done), .swclk_o(swclk),
    .swdio_o(dout), .swdio_oe_o(oe), .swdio_i(din));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(bit o, bit d, bit ti, string tag);
    q_oe.push_back(o); q_do.push_back(d); q_ti.push_back(ti); q_tag.push_back(tag);
  endtask

  task automatic run_xact(bit a_p, bit r, logic [1:0] ad, logic [31:0] wd, bit ig,
                          logic [2:0] tack, logic [31:0] td, bit flip, bit poke, string rtag);
    bit ok = (tack == 3'b001);
    bit exp_pe = 1'b0;
    q_oe.delete(); q_do.delete(); q_ti.delete(); q_tag.delete();
    push(1, 1, 0, "R1"); push(1, a_p, 0, "R1"); push(1, r, 0, "R1");
    push(1, ad[0], 0, "R1"); push(1, ad[1], 0, "R1");
    push(1, a_p ^ r ^ ad[0] ^ ad[1], 0, "R2");
    push(1, 0, 0, "R1"); push(1, 1, 0, "R1");
    push(0, 0, 1, "R4");
    for (int i = 0; i < 3; i++) push(0, 0, tack[i], "R4");
    if (r) begin
      if (ok) begin
        for (int i = 0; i < 32; i++) push(0, 0, td[i], "R6");
        push(0, 0, (^td) ^ flip, "R6");
        push(1, 0, 0, "R6");
        exp_rd = td; exp_pe = flip;
      end else push(1, 0, 0, "R7");
    end else begin
      if (ok || ig) begin
        push(1, 0, 0, "R5");
        for (int i = 0; i < 32; i++) push(1, wd[i], 0, ig ? "R8" : "R5");
        push(1, ^wd, 0, "R5");
      end else push(1, 0, 0, "R7");
    end
    ap = a_p; rnw = r; addr = ad; wdata = wd; ign = ig; req = 1'b1;
    for (int b = 0; b < q_oe.size(); b++) begin
      for (int c = 0; c < 2*H; c++) begin
        string t;
        @(negedge clk);
        if (b == 0 && c == 0) req = 1'b0;
        if (poke && b == 10 && c == 1) begin req = 1'b1; rnw = !r; ap = !a_p; end
        if (poke && b == 10 && c == 2) req = 1'b0;
        if (c == 0 && !q_oe[b]) din = q_ti[b];
        t = (poke && b >= 10) ? "R11" : q_tag[b];
        chk(poke && b >= 10 ? "R11" : "R3", 32'(swclk), 32'(c >= H));
        chk(t, 32'(oe), 32'(q_oe[b]));
        if (q_oe[b]) chk(t, 32'(dout), 32'(q_do[b]));
        chk("R10", 32'(done), 32'd0);
      end
    end
    @(negedge clk);
    chk("R10", 32'(done), 32'd1);
    chk("R10", 32'({swclk, oe, dout}), 32'b010);
    chk(rtag, 32'(ack), 32'(tack));
    chk(r && ok ? "R6" : rtag, rdata, exp_rd);
    chk("R9", 32'(perr), 32'(exp_pe));
    @(negedge clk);
    chk("R10", 32'(done), 32'd0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", 32'({swclk, oe, dout, done, perr}), 32'b01000);
    chk("R10", 32'(ack), 32'd0);
    chk("R10", rdata, 32'd0);
    // R5 plain write to an access-port register
    run_xact(1, 0, 2'b10, 32'hA5C3_0F96, 0, 3'b001, 32'h0, 0, 0, "R5");
    // R6 read with correct parity
    run_xact(0, 1, 2'b00, 32'h0, 0, 3'b001, 32'h1357_9BDF, 0, 0, "R6");
    // R9 read with corrupted parity, data still returned
    run_xact(1, 1, 2'b11, 32'h0, 0, 3'b001, 32'hFEDC_0123, 1, 0, "R9");
    // R7 read with WAIT, data held
    run_xact(0, 1, 2'b01, 32'h0, 0, 3'b010, 32'hDEAD_BEEF, 0, 0, "R7");
    // R7 write with FAULT, no data phase
    run_xact(1, 0, 2'b01, 32'h7777_0000, 0, 3'b100, 32'h0, 0, 0, "R7");
    // R8 write with no response but ignore set
    run_xact(0, 0, 2'b11, 32'h0123_4567, 1, 3'b111, 32'h0, 0, 0, "R8");
    // R8 ignore has no effect on a read
    run_xact(0, 1, 2'b10, 32'h0, 1, 3'b111, 32'h5555_AAAA, 0, 0, "R8");
    // R11 request pulse during transfer
    run_xact(1, 0, 2'b00, 32'h8000_0001, 0, 3'b001, 32'h0, 0, 1, "R11");
    // R2 every header combination
    for (int k = 0; k < 16; k++)
      run_xact(k[3], k[2], k[1:0], 32'h1 << k, 0, 3'b001, ~(32'h1 << k), 0, 0, "R2");
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule